// File: doc/BRIEF.md
# Quad Double-Buffered DAC Register File

This block is the digital front end of a four-channel converter that is loaded over a parallel bus. Every channel has two registers. A staging register takes the bus word when the write strobe is low and the 2-bit channel address selects that channel. A second register, the one the converter reads, takes a copy of the staging register when the load strobe is low. This lets software stage new codes on all four channels and then change every output together.

Both strobes are active low and are treated as asynchronous. They pass through a two-flop synchroniser on the system clock. The address and data travel through the same flops, so they stay aligned with their strobe. An active-high shutdown input blanks all code outputs and raises a power-down flag for each channel. The registers keep their contents and keep working during shutdown. Analog conversion and reference switching are outside this block.

Top module: `dacq_regfile`

## Requirements
- R1: An asynchronous active-low reset clears every staging register and every converter register to zero, so every code output reads 0.
- R2: With the write strobe low and the load strobe high, only the staging register of the addressed channel takes the bus data (address 0 selects channel 0 up to address 3 for channel 3). No converter register changes, so the code outputs stay as they were.
- R3: With the load strobe low and the write strobe high, all four converter registers copy their staging registers, and the address has no effect on the result.
- R4: With both strobes low, the addressed staging register takes the bus data. At the same time every converter register loads: the addressed one gets the new bus data and the others copy their staging registers.
- R5: With both strobes high, no register changes, whatever the address and data buses carry.
- R6: A strobe driven low just after a falling clock edge takes effect on the third rising edge after that. Address and data are taken from the same cycle as the strobe. A level held low acts again on every cycle.
- R7: While shutdown is high, every power-down flag reads 1 and every code output reads 0, in the same cycle and without waiting for a clock edge. While shutdown is low, every flag reads 0.
- R8: Shutdown does not clear or freeze the registers. When shutdown returns low, each output shows the code held in its converter register, including any loads made during shutdown.
- R9: Channel c's code appears on `code_o[c*DATA_W +: DATA_W]`, bit 0 being the least significant, and always comes from that channel's converter register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_n | input | 1 | Active-low staging write strobe |
| ld_n | input | 1 | Active-low converter load strobe |
| addr_i | input | ADDR_W (2) | Channel select for writes |
| data_i | input | DATA_W | Bus data word |
| shdn_i | input | 1 | Active-high shutdown |
| code_o | output | NCH*DATA_W | Packed per-channel codes, channel 0 in the low bits |
| pd_o | output | NCH | Per-channel power-down flags |

## Verification
The bench builds the block with a 10-bit data width and the default four channels and two synchroniser stages. The 10-bit width means a wrong slice offset in the packed output is caught, and an all-ones code exposes a truncated top bit. Keeping two stages puts the three-edge strobe latency and the case where both strobes are low in the same cycle within reach of short directed sequences. A long random phase then mixes all four strobe combinations with shutdown.

// File: rtl/dacq_pkg.sv
package dacq_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_LOAD  = 2'd2,
    OP_BOTH  = 2'd3
  } dacq_op_e;

  function automatic dacq_op_e decode_op(input logic wr_fire, input logic ld_fire);
    dacq_op_e op;
    case ({wr_fire, ld_fire})
      2'b10:   op = OP_WRITE;
      2'b01:   op = OP_LOAD;
      2'b11:   op = OP_BOTH;
      default: op = OP_IDLE;
    endcase
    return op;
  endfunction

  function automatic logic addr_hit(input int unsigned addr, input int unsigned idx);
    return addr == idx;
  endfunction

endpackage

// File: rtl/dacq_sync.sv
module dacq_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dacq_chan.sv
module dacq_chan
  import dacq_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dacq_op_e          op,
  input  logic              hit,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] in_q,
  output logic [DATA_W-1:0] dac_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      dac_q <= '0;
    end else begin
      case (op)
        OP_WRITE: if (hit) in_q <= data;
        OP_LOAD:  dac_q <= in_q;
        OP_BOTH: begin
          if (hit) in_q <= data;
          dac_q <= hit ? data : in_q;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dacq_outgate.sv
module dacq_outgate #(
  parameter int NCH = 4,
  parameter int DATA_W = 12
) (
  input  logic                  shdn,
  input  logic [NCH*DATA_W-1:0] dac_flat,
  output logic [NCH*DATA_W-1:0] code_o,
  output logic [NCH-1:0]        pd_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_gate
    assign code_o[c*DATA_W +: DATA_W] = shdn ? '0 : dac_flat[c*DATA_W +: DATA_W];
    assign pd_o[c] = shdn;
  end
endmodule

// File: rtl/dacq_regfile.sv
module dacq_regfile
  import dacq_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int NCH = 4,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_n,
  input  logic                  ld_n,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     data_i,
  input  logic                  shdn_i,
  output logic [NCH*DATA_W-1:0] code_o,
  output logic [NCH-1:0]        pd_o
);
  localparam int BUN_W = 2 + ADDR_W + DATA_W;
  localparam logic [BUN_W-1:0] BUN_RST = {2'b11, {(ADDR_W + DATA_W){1'b0}}};

  logic [BUN_W-1:0]      bun_q;
  logic                  wr_n_s;
  logic                  ld_n_s;
  logic [ADDR_W-1:0]     addr_s;
  logic [DATA_W-1:0]     data_s;
  logic                  wr_fire;
  logic                  ld_fire;
  dacq_op_e              op;
  logic [NCH-1:0]        chan_hit;
  logic [NCH*DATA_W-1:0] in_q;
  logic [NCH*DATA_W-1:0] dac_q;

  dacq_sync #(
    .WIDTH  (BUN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(BUN_RST)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({wr_n, ld_n, addr_i, data_i}),
    .q    (bun_q)
  );

  assign {wr_n_s, ld_n_s, addr_s, data_s} = bun_q;
  assign wr_fire = ~wr_n_s;
  assign ld_fire = ~ld_n_s;
  assign op      = decode_op(wr_fire, ld_fire);

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign chan_hit[c] = addr_hit(32'(addr_s), c);

    dacq_chan #(.DATA_W(DATA_W)) u_chan (
      .clk  (clk),
      .rst_n(rst_n),
      .op   (op),
      .hit  (chan_hit[c]),
      .data (data_s),
      .in_q (in_q[c*DATA_W +: DATA_W]),
      .dac_q(dac_q[c*DATA_W +: DATA_W])
    );
  end

  dacq_outgate #(.NCH(NCH), .DATA_W(DATA_W)) u_gate (
    .shdn    (shdn_i),
    .dac_flat(dac_q),
    .code_o  (code_o),
    .pd_o    (pd_o)
  );
endmodule

// File: rtl/dacq_regfile_chk.sv
module dacq_regfile_chk #(
  parameter int DATA_W = 12,
  parameter int NCH = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  shdn_i,
  input logic                  wr_fire,
  input logic                  ld_fire,
  input logic [NCH*DATA_W-1:0] in_q,
  input logic [NCH*DATA_W-1:0] dac_q,
  input logic [NCH*DATA_W-1:0] code_o,
  input logic [NCH-1:0]        pd_o
);
  logic [NCH*DATA_W-1:0] in_prev;
  logic [NCH-1:0]        in_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_prev <= '0;
    else        in_prev <= in_q;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chg
    assign in_chg[c] = in_q[c*DATA_W +: DATA_W] != in_prev[c*DATA_W +: DATA_W];
  end

  AST_SHDN_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_i |-> (code_o == '0) && (pd_o == '1)); // R7

  AST_OUT_TRACKS_DAC: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_i |-> (code_o == dac_q) && (pd_o == '0)); // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_fire && !ld_fire) |=> $stable(in_q) && $stable(dac_q)); // R5

  AST_DAC_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_fire |=> $stable(dac_q)); // R2

  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fire && !wr_fire) |=> dac_q == $past(in_q)); // R3

  AST_BOTH_ALIGNS: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fire && wr_fire) |=> dac_q == in_q); // R4

  AST_ONE_INPUT_CHANGES: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_chg)); // R2
endmodule

bind dacq_regfile dacq_regfile_chk #(.DATA_W(DATA_W), .NCH(NCH)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .shdn_i (shdn_i),
  .wr_fire(wr_fire),
  .ld_fire(ld_fire),
  .in_q   (in_q),
  .dac_q  (dac_q),
  .code_o (code_o),
  .pd_o   (pd_o)
);

// File: tb/tb_dacq_regfile.sv
`timescale 1ns/1ps
module tb_dacq_regfile;
  localparam int W = 10;
  localparam int N = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_n = 1'b1;
  logic           ld_n = 1'b1;
  logic [1:0]     addr = '0;
  logic [W-1:0]   data = '0;
  logic           shdn = 1'b0;
  logic [N*W-1:0] code_o;
  logic [N-1:0]   pd_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit running = 0;
  string cur_req = "R1";

  int in_m [N];
  int dac_m [N];
  int q_wr [$];
  int q_ld [$];
  int q_ad [$];
  int q_dt [$];

  always #5 clk = ~clk;

  dacq_regfile #(.DATA_W(W), .NCH(N), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .ld_n(ld_n), .addr_i(addr),
    .data_i(data), .shdn_i(shdn), .code_o(code_o), .pd_o(pd_o)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
    end
  endtask

  // behavioural reference: two-deep queue of sampled bus states, then register update
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < N; c++) begin in_m[c] = 0; dac_m[c] = 0; end
      q_wr = '{1, 1}; q_ld = '{1, 1}; q_ad = '{0, 0}; q_dt = '{0, 0};
    end else begin
      int w, l, a, d;
      w = q_wr.pop_front(); l = q_ld.pop_front();
      a = q_ad.pop_front(); d = q_dt.pop_front();
      if (l == 0)
        for (int c = 0; c < N; c++) dac_m[c] = (w == 0 && c == a) ? d : in_m[c];
      if (w == 0) in_m[a] = d;
      q_wr.push_back(int'(wr_n)); q_ld.push_back(int'(ld_n));
      q_ad.push_back(int'(addr)); q_dt.push_back(int'(data));
    end
  end

  always @(negedge clk) begin
    if (rst_n && running) begin
      for (int c = 0; c < N; c++)
        chk(cur_req, int'(code_o[c*W +: W]), shdn ? 0 : dac_m[c]);
      chk(cur_req, int'(pd_o), shdn ? 4'hF : 4'h0);
    end
  end

  task automatic drive(input bit w, input bit l, input int a, input int d);
    @(negedge clk); #1;
    wr_n = w; ld_n = l; addr = a[1:0]; data = d[W-1:0];
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1, 1, $urandom_range(3), $urandom_range(1023));
  endtask

  task automatic chk_all(input string req, input int e0, input int e1, input int e2, input int e3);
    chk(req, int'(code_o[0*W +: W]), e0);
    chk(req, int'(code_o[1*W +: W]), e1);
    chk(req, int'(code_o[2*W +: W]), e2);
    chk(req, int'(code_o[3*W +: W]), e3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1; chk_all("R1", 0, 0, 0, 0);
    rst_n = 1'b1; running = 1;
    idle(3);
    chk_all("R1", 0, 0, 0, 0);

    // R2: staging writes only
    cur_req = "R2";
    drive(0, 1, 0, 'h011); drive(0, 1, 1, 'h2A3);
    drive(0, 1, 2, 'h155); drive(0, 1, 3, 'h3FF);
    idle(4);
    chk_all("R2", 0, 0, 0, 0);

    // R3: load, address ignored
    cur_req = "R3";
    drive(1, 0, 2, 'h000);
    idle(4);
    chk_all("R3", 'h011, 'h2A3, 'h155, 'h3FF);
    chk("R9", int'(code_o[39:30]), 'h3FF);
    chk("R9", int'(code_o[19:10]), 'h2A3);

    // R2: a new staged value is not visible until a load
    cur_req = "R2";
    drive(0, 1, 1, 'h0F0);
    idle(4);
    chk_all("R2", 'h011, 'h2A3, 'h155, 'h3FF);

    // R6: load takes effect on the third rising edge
    cur_req = "R6";
    drive(1, 0, 0, 'h000);
    idle(1); chk("R6", int'(code_o[1*W +: W]), 'h2A3);
    idle(1); chk("R6", int'(code_o[1*W +: W]), 'h2A3);
    idle(1); chk("R6", int'(code_o[1*W +: W]), 'h0F0);

    // R4: both strobes together
    cur_req = "R4";
    drive(0, 1, 0, 'h222);
    drive(0, 0, 3, 'h1C3);
    idle(4);
    chk_all("R4", 'h222, 'h0F0, 'h155, 'h1C3);

    // R5: idle with busy buses
    cur_req = "R5";
    idle(20);
    chk_all("R5", 'h222, 'h0F0, 'h155, 'h1C3);

    // R7/R8: shutdown
    cur_req = "R7";
    @(negedge clk); #1 shdn = 1'b1;
    #1;
    chk_all("R7", 0, 0, 0, 0);
    chk("R7", int'(pd_o), 'hF);
    drive(0, 1, 2, 'h0AB); drive(1, 0, 0, 0);
    idle(4);
    chk_all("R7", 0, 0, 0, 0);
    cur_req = "R8";
    @(negedge clk); #1 shdn = 1'b0;
    #1;
    chk_all("R8", 'h222, 'h0F0, 'h0AB, 'h1C3);
    chk("R7", int'(pd_o), 0);

    // R1: reset mid-run
    @(negedge clk); #1 rst_n = 1'b0;
    #1; chk_all("R1", 0, 0, 0, 0);
    @(negedge clk); #1 rst_n = 1'b1;
    idle(3);

    // random mix
    cur_req = "R2,R3,R4,R5,R7";
    for (int i = 0; i < 600; i++) begin
      drive(($urandom_range(2) != 0), ($urandom_range(3) != 0),
            $urandom_range(3), $urandom_range(1023));
      if ($urandom_range(15) == 0) shdn = ~shdn;
    end
    shdn = 1'b0;
    idle(4);
    running = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule